// File: doc/BRIEF.md
# Protected Page-Write Commit Unit

This block sits behind a two-wire serial protocol engine and owns the write path into a 256 x 8 storage array. The engine gives it a strobe at the start of each write transaction, carrying the word address. It then sends one strobe per received data byte and a strobe when the stop condition arrives. The block gathers the data bytes in a 16-slot page buffer. The slot index is the low four bits of a running pointer, and the upper address bits stay fixed for the whole transaction. Nothing reaches the array until the stop.

After the stop, the block runs a self-timed write cycle of `TWR_CYCLES` clocks and reports it on `busy_o`. In the first 16 clocks of that cycle it scans the buffer slots in ascending order. For each slot loaded in this transaction it drives one array write, unless protection forbids that address. Two mechanisms protect the array. A one-time lock, set by a request from the engine, covers the lower half of the array for good. A pin covers the whole array and also blocks setting the lock. A write refused by protection still costs the full cycle time.

The lock flop is reset only by the power-on reset `por_ni`, so it models non-volatile state. The soft reset `rst_ni` clears everything else.

Top module: `page_commit_unit`

## Requirements
- R1: While either reset is low, and in the first cycle after it is released, `busy_o` and `mem_we_o` are low.
- R2: Each data byte accepted after a start is stored in the slot given by the pointer's low 4 bits, and the pointer then increments modulo 16. The pointer starts at `start_addr_i[3:0]`, and writes of that transaction go to `{start_addr_i[7:4], slot}`.
- R3: When more than 16 data bytes arrive before the stop, the pointer wraps, and a later byte replaces the earlier byte held in the same slot.
- R4: No array write happens before the stop. A stop with at least one byte loaded raises `busy_o` on the next clock and holds it for exactly `TWR_CYCLES` clocks.
- R5: During the first 16 busy clocks, one slot is examined per clock in ascending order, and only slots loaded in this transaction are written. Untouched addresses of the page get no write.
- R6: A stop with no data byte loaded, such as after a bare word address, starts no write cycle and leaves `busy_o` low.
- R7: A lock request with `wp_i` low, while not busy, sets the lock and runs one write cycle. After that no address with bit 7 = 0 (00h to 7Fh) is written again, and the lock is cleared by `por_ni` only, never by `rst_ni`.
- R8: If `wp_i` is high when the stop is accepted, that write cycle writes nothing. A lock request while `wp_i` is high is ignored and starts no cycle.
- R9: A write refused by protection still holds `busy_o` for the full `TWR_CYCLES` clocks.
- R10: While `busy_o` is high, start, byte, stop and lock strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Soft reset, asynchronous, active low; keeps the lock |
| por_ni | input | 1 | Power-on reset, asynchronous, active low; clears everything including the lock |
| start_i | input | 1 | Write transaction start strobe with word address |
| start_addr_i | input | 8 | Word address of the transaction |
| byte_vld_i | input | 1 | Data byte received strobe |
| byte_i | input | 8 | Received data byte |
| stop_i | input | 1 | Stop condition strobe |
| lock_req_i | input | 1 | Request to set the lower-half lock |
| wp_i | input | 1 | Write-protect pin level, high protects all |
| busy_o | output | 1 | Write cycle in progress |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | 8 | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
The bench keeps the default 8-bit address, 8-bit data and 16-slot geometry, and sets `TWR_CYCLES` to 24. With that setting, each write cycle ends soon after its 16-clock scan, so every scenario fits in a short run. It still leaves room for eight clocks of stray strobes inside a busy window. The short cycle lets the bench count every busy clock exactly and also check the lock across a soft reset. It can also run wrapped 18-byte pages and pin-protected cycles back to back.

// File: rtl/page_commit_pkg.sv
package page_commit_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_CYCLE = 2'd2
  } pcu_state_e;
endpackage

// File: rtl/pcu_page_buffer.sv
module pcu_page_buffer #(
  parameter int DATA_W = 8,
  parameter int SLOT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic [SLOT_W-1:0] init_slot_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              drop_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              any_valid_o
);
  localparam int SLOTS = 1 << SLOT_W;

  logic [SLOT_W-1:0]             wr_ptr_q;
  logic [SLOTS-1:0]              valid_w;
  logic [SLOTS-1:0][DATA_W-1:0]  data_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wr_ptr_q <= '0;
    else if (init_i) wr_ptr_q <= init_slot_i;
    else if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic              hit;
    logic              vld_q;
    logic [DATA_W-1:0] dat_q;

    assign hit = push_i && (wr_ptr_q == SLOT_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               vld_q <= 1'b0;
      else if (init_i || drop_i) vld_q <= 1'b0;
      else if (hit)              vld_q <= 1'b1;
    end

    // later bytes replace earlier ones in the same slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  dat_q <= '0;
      else if (hit) dat_q <= push_data_i;
    end

    assign valid_w[g] = vld_q;
    assign data_w[g]  = dat_q;
  end

  assign rd_data_o   = data_w[rd_slot_i];
  assign rd_valid_o  = valid_w[rd_slot_i];
  assign any_valid_o = |valid_w;
endmodule

// File: rtl/pcu_protect.sv
module pcu_protect #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              lock_set_i,
  input  logic              wp_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              lock_o,
  output logic              allow_o
);
  logic lock_q;
  logic wp_q;
  logic low_half;

  // survives soft reset: models non-volatile bit
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                  lock_q <= 1'b0;
    else if (lock_set_i && !wp_i) lock_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wp_q <= 1'b0;
    else if (capture_i) wp_q <= wp_i;
  end

  assign low_half = ~addr_i[ADDR_W-1];
  assign lock_o   = lock_q;
  assign allow_o  = !wp_q && !(lock_q && low_half);
endmodule

// File: rtl/pcu_cycle_ctrl.sv
module pcu_cycle_ctrl
  import page_commit_pkg::*;
#(
  parameter int SLOT_W     = 4,
  parameter int TWR_CYCLES = 2000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              byte_vld_i,
  input  logic              stop_i,
  input  logic              lock_req_i,
  input  logic              wp_i,
  input  logic              any_valid_i,
  output logic              busy_o,
  output logic              init_o,
  output logic              push_o,
  output logic              drop_o,
  output logic              capture_o,
  output logic              lock_set_o,
  output logic [SLOT_W-1:0] scan_slot_o,
  output logic              scan_o
);
  localparam int SLOTS = 1 << SLOT_W;
  localparam int CNT_W = $clog2(TWR_CYCLES + 1);

  pcu_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last = (cnt_q == CNT_W'(TWR_CYCLES - 1));

  always_comb begin
    state_d    = state_q;
    init_o     = 1'b0;
    push_o     = 1'b0;
    drop_o     = 1'b0;
    capture_o  = 1'b0;
    lock_set_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          init_o  = 1'b1;
          state_d = ST_FILL;
        end else if (lock_req_i && !wp_i) begin
          lock_set_o = 1'b1;
          drop_o     = 1'b1;
          state_d    = ST_CYCLE;
        end
      end
      ST_FILL: begin
        if (stop_i) begin
          if (any_valid_i) begin
            capture_o = 1'b1;
            state_d   = ST_CYCLE;
          end else begin
            state_d = ST_IDLE;
          end
        end else if (start_i) begin
          init_o = 1'b1;
        end else if (lock_req_i && !wp_i) begin
          lock_set_o = 1'b1;
          drop_o     = 1'b1;
          state_d    = ST_CYCLE;
        end else if (byte_vld_i) begin
          push_o = 1'b1;
        end
      end
      ST_CYCLE: begin
        if (last) begin
          drop_o  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (state_q != ST_CYCLE) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  assign busy_o      = (state_q == ST_CYCLE);
  assign scan_o      = busy_o && (cnt_q < CNT_W'(SLOTS));
  assign scan_slot_o = cnt_q[SLOT_W-1:0];
endmodule

// File: rtl/page_commit_unit.sv
module page_commit_unit #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int SLOT_W     = 4,
  parameter int TWR_CYCLES = 2000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              stop_i,
  input  logic              lock_req_i,
  input  logic              wp_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam int PAGE_W = ADDR_W - SLOT_W;

  logic              sys_rst_n;
  logic              init, push, drop, capture, lock_set;
  logic              scan, rd_valid, any_valid, allow, lock_q;
  logic [SLOT_W-1:0] scan_slot;
  logic [DATA_W-1:0] rd_data;
  logic [PAGE_W-1:0] page_q;

  assign sys_rst_n = rst_ni & por_ni;

  pcu_cycle_ctrl #(.SLOT_W(SLOT_W), .TWR_CYCLES(TWR_CYCLES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (sys_rst_n),
    .start_i     (start_i),
    .byte_vld_i  (byte_vld_i),
    .stop_i      (stop_i),
    .lock_req_i  (lock_req_i),
    .wp_i        (wp_i),
    .any_valid_i (any_valid),
    .busy_o      (busy_o),
    .init_o      (init),
    .push_o      (push),
    .drop_o      (drop),
    .capture_o   (capture),
    .lock_set_o  (lock_set),
    .scan_slot_o (scan_slot),
    .scan_o      (scan)
  );

  pcu_page_buffer #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (sys_rst_n),
    .init_i      (init),
    .init_slot_i (start_addr_i[SLOT_W-1:0]),
    .push_i      (push),
    .push_data_i (byte_i),
    .drop_i      (drop),
    .rd_slot_i   (scan_slot),
    .rd_data_o   (rd_data),
    .rd_valid_o  (rd_valid),
    .any_valid_o (any_valid)
  );

  always_ff @(posedge clk_i or negedge sys_rst_n) begin
    if (!sys_rst_n) page_q <= '0;
    else if (init)  page_q <= start_addr_i[ADDR_W-1:SLOT_W];
  end

  assign mem_addr_o  = {page_q, scan_slot};
  assign mem_wdata_o = rd_data;

  pcu_protect #(.ADDR_W(ADDR_W)) u_prot (
    .clk_i      (clk_i),
    .rst_ni     (sys_rst_n),
    .por_ni     (por_ni),
    .lock_set_i (lock_set),
    .wp_i       (wp_i),
    .capture_i  (capture),
    .addr_i     (mem_addr_o),
    .lock_o     (lock_q),
    .allow_o    (allow)
  );

  assign mem_we_o = scan && rd_valid && allow;
endmodule

// File: rtl/page_commit_chk.sv
module page_commit_chk #(
  parameter int ADDR_W     = 8,
  parameter int TWR_CYCLES = 2000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              por_ni,
  input logic              start_i,
  input logic              byte_vld_i,
  input logic              stop_i,
  input logic              lock_req_i,
  input logic              wp_i,
  input logic              busy_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              lock_q
);
  logic rst_all_n;
  logic seen_byte_q;
  logic wp_stop_q;
  int   bcnt_q;

  assign rst_all_n = rst_ni & por_ni;

  always_ff @(posedge clk_i or negedge rst_all_n) begin
    if (!rst_all_n) begin
      seen_byte_q <= 1'b0;
      wp_stop_q   <= 1'b0;
      bcnt_q      <= 0;
    end else begin
      if (busy_o || start_i || lock_req_i) seen_byte_q <= 1'b0;
      else if (byte_vld_i)                 seen_byte_q <= 1'b1;
      if (stop_i && !busy_o) wp_stop_q <= wp_i;
      bcnt_q <= busy_o ? bcnt_q + 1 : 0;
    end
  end

  // R5
  we_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_all_n)
    mem_we_o |-> busy_o);

  // R4
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_all_n)
    (!busy_o && bcnt_q != 0) |-> (bcnt_q == TWR_CYCLES));

  // R9
  busy_max_chk: assert property (@(posedge clk_i) disable iff (!rst_all_n)
    busy_o |-> (bcnt_q < TWR_CYCLES));

  // R6
  empty_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_all_n)
    (stop_i && !busy_o && !seen_byte_q && !byte_vld_i && !lock_req_i && !start_i) |=> !busy_o);

  // R7
  lock_keep_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    lock_q |=> lock_q);

  // R7
  lock_low_chk: assert property (@(posedge clk_i) disable iff (!rst_all_n)
    (mem_we_o && lock_q) |-> mem_addr_o[ADDR_W-1]);

  // R8
  wp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_all_n)
    mem_we_o |-> !wp_stop_q);

  // R10
  lock_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_all_n)
    busy_o |=> $stable(lock_q));
endmodule

bind page_commit_unit page_commit_chk #(.ADDR_W(ADDR_W), .TWR_CYCLES(TWR_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .por_ni     (por_ni),
  .start_i    (start_i),
  .byte_vld_i (byte_vld_i),
  .stop_i     (stop_i),
  .lock_req_i (lock_req_i),
  .wp_i       (wp_i),
  .busy_o     (busy_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .lock_q     (lock_q)
);

// File: tb/page_commit_unit_tb_top.sv
`timescale 1ns/1ps
module page_commit_unit_tb_top;
  localparam int TWR = 24;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0, por_ni = 1'b0;
  logic       start_i = 1'b0, byte_vld_i = 1'b0, stop_i = 1'b0;
  logic       lock_req_i = 1'b0, wp_i = 1'b0;
  logic [7:0] start_addr_i = '0, byte_i = '0;
  logic       busy_o, mem_we_o;
  logic [7:0] mem_addr_o, mem_wdata_o;

  int errors = 0;
  int checks = 0;
  bit mon_en = 1'b0;

  typedef struct {
    logic [7:0] a;
    logic [7:0] d;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  page_commit_unit #(.TWR_CYCLES(TWR)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni),
    .start_i(start_i), .start_addr_i(start_addr_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .stop_i(stop_i),
    .lock_req_i(lock_req_i), .wp_i(wp_i),
    .busy_o(busy_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_en && mem_we_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", "unexpected write addr", int'(mem_addr_o), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(mem_addr_o == e.a && mem_wdata_o == e.d, e.req, "write addr/data",
              int'({mem_addr_o, mem_wdata_o}), int'({e.a, e.d}));
      end
    end
  end

  task automatic pulse_start(input logic [7:0] a);
    @(negedge clk); start_i = 1'b1; start_addr_i = a;
    @(negedge clk); start_i = 1'b0;
  endtask
  task automatic pulse_byte(input logic [7:0] d);
    @(negedge clk); byte_vld_i = 1'b1; byte_i = d;
    @(negedge clk); byte_vld_i = 1'b0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
  endtask
  task automatic pulse_lock();
    @(negedge clk); lock_req_i = 1'b1;
    @(negedge clk); lock_req_i = 1'b0;
  endtask

  task automatic busy_run(input int exp_len, input string req);
    int n = 0;
    while (busy_o && n < 4 * TWR) begin
      n++;
      @(negedge clk);
    end
    check(n == exp_len, req, "busy length", n, exp_len);
  endtask

  task automatic queue_empty(input string req);
    check(exp_q.size() == 0, req, "missing writes", exp_q.size(), 0);
  endtask

  task automatic run_txn(input logic [7:0] addr, input int n, input logic [7:0] seed,
                         input logic wp, input logic lk, input string req);
    logic [7:0] ed [16];
    bit         ev [16];
    for (int s = 0; s < 16; s++) ev[s] = 1'b0;
    wp_i = wp;
    pulse_start(addr);
    for (int i = 0; i < n; i++) begin
      int s = (int'(addr) + i) % 16;
      ed[s] = seed + 8'(i);
      ev[s] = 1'b1;
      pulse_byte(seed + 8'(i));
      // R4: nothing happens before the stop
      check(!busy_o && !mem_we_o, "R4", "activity before stop", int'({busy_o, mem_we_o}), 0);
    end
    for (int s = 0; s < 16; s++)
      if (ev[s] && !wp && !(lk && !addr[7]))
        exp_q.push_back('{a: {addr[7:4], 4'(s)}, d: ed[s], req: req});
    pulse_stop();
    busy_run(n > 0 ? TWR : 0, req);
    queue_empty(req);
    wp_i = 1'b0;
  endtask

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs low in reset
    check(!busy_o && !mem_we_o, "R1", "outputs in reset", int'({busy_o, mem_we_o}), 0);
    por_ni = 1'b1; rst_ni = 1'b1;
    @(negedge clk);
    check(!busy_o && !mem_we_o, "R1", "outputs after reset", int'({busy_o, mem_we_o}), 0);
    mon_en = 1'b1;

    run_txn(8'h85, 1, 8'h3C, 1'b0, 1'b0, "R4");   // single byte, R5
    run_txn(8'h9E, 5, 8'h50, 1'b0, 1'b0, "R2");   // wraps inside page
    run_txn(8'hA0, 18, 8'h11, 1'b0, 1'b0, "R3");  // overwrite of slots 0,1
    run_txn(8'h30, 0, 8'h00, 1'b0, 1'b0, "R6");   // stop with no data
    run_txn(8'hC4, 3, 8'h77, 1'b1, 1'b0, "R8");   // pin protect, R9 full cycle

    // R8: lock request ignored while pin high
    wp_i = 1'b1;
    pulse_lock();
    check(!busy_o, "R8", "busy after lock req with pin high", int'(busy_o), 0);
    wp_i = 1'b0;
    run_txn(8'h10, 2, 8'hA5, 1'b0, 1'b0, "R8");

    // R10: strobes during busy ignored
    pulse_start(8'h40);
    pulse_byte(8'hE1);
    exp_q.push_back('{a: 8'h40, d: 8'hE1, req: "R10"});
    pulse_stop();
    pulse_start(8'h50);
    pulse_byte(8'h99);
    pulse_stop();
    pulse_lock();
    busy_run(TWR - 8, "R10");
    queue_empty("R10");
    repeat (3) @(negedge clk);
    check(!busy_o, "R10", "no cycle from ignored stop", int'(busy_o), 0);
    run_txn(8'h20, 1, 8'h5A, 1'b0, 1'b0, "R10");  // lock not set by ignored request

    // R7: set the lock
    pulse_lock();
    busy_run(TWR, "R7");
    run_txn(8'h12, 2, 8'h66, 1'b0, 1'b1, "R7");   // R9 refused write, full cycle
    run_txn(8'h92, 2, 8'h67, 1'b0, 1'b1, "R7");   // upper half still writable

    // R7: soft reset keeps the lock
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    check(!busy_o, "R1", "busy after soft reset", int'(busy_o), 0);
    run_txn(8'h05, 1, 8'hC3, 1'b0, 1'b1, "R7");
    run_txn(8'hF0, 1, 8'hC4, 1'b0, 1'b1, "R9");

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule